// File: doc/BRIEF.md
# Memory-Mapped Interrupt Group Bank

This block gathers interrupt sources into banks of 32 cause bits and ranks them by severity. Each bank is a group with its own 64-byte register window. Windows sit back to back, so the whole block spans 0x40 times the group count. Software reaches the registers through a plain same-clock memory port: an address, a write enable, write data, and read data that follows the address in the same cycle. Every group latches its triggers into cause bits. Software can set cause bits, clear them by writing zeros, and mask them for status. Each group drives three severity lines, abort, fatal and log, and the block also drives an OR of each line across all groups.

Triggers are level sensitive by default. A control bit switches a whole group to rising-edge capture. The status mask comes out of reset with every source unmasked. The three severity masks come out of reset with everything masked, so no severity line can fire until software opens one.

Top module: `irq_grp_bank`

## Requirements
- R1: Group g occupies addresses g*0x40 to g*0x40+0x3F, and address bits [5:0] select the register. The offsets are 0x00 cause, 0x08 set, 0x10 mask, 0x18 mask-clear, 0x20 status, 0x28 control, 0x30 abort mask, 0x34 fatal mask and 0x38 log mask. Any other offset reads 0, and a write to it changes nothing.
- R2: After reset, cause, mask and control read 0x00000000, the abort, fatal and log masks read 0xFFFFFFFF, and every severity output is low.
- R3: A write to the cause offset clears each cause bit whose data bit is 0 and leaves the bits written 1 unchanged.
- R4: A write to the set offset sets each cause bit whose data bit is 1.
- R5: A write to the mask offset loads the mask. A write to the mask-clear offset clears each mask bit whose data bit is 0.
- R6: The status offset reads cause AND NOT mask. Writes to it have no effect.
- R7: The control register stores bits [27:16], [11:8], 5 and [3:0] and reads them back. Bit 4 is write-only and every other bit reads 0, so writing 0xFFFFFFFF reads back 0x0FFF0F2F.
- R8: The set and mask-clear offsets always read 0.
- R9: With control bit 3 at 0, a trigger that is high sets its cause bit on every clock. A trigger that is high in the same cycle as a software clear of that bit keeps the bit set.
- R10: With control bit 3 at 1, a cause bit is set only on a low-to-high transition of its trigger. A trigger held high does not set the bit again after it has been cleared.
- R11: Each group's abort, fatal and log output is the OR over all 32 bits of cause AND NOT the matching severity mask. The status mask has no effect on these outputs.
- R12: Each top-level severity output is the OR of that severity across all groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | NGROUPS*32 | Trigger inputs; group g uses bits [g*32+31:g*32] |
| addr_i | input | AW | Byte address, AW = log2(0x40*NGROUPS) |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| grp_abort_o | output | NGROUPS | Per-group abort severity |
| grp_fatal_o | output | NGROUPS | Per-group fatal severity |
| grp_log_o | output | NGROUPS | Per-group log severity |
| any_abort_o | output | 1 | Abort OR across groups |
| any_fatal_o | output | 1 | Fatal OR across groups |
| any_log_o | output | 1 | Log OR across groups |

## Verification
Assertions check five properties on every cycle:
- at most one group window is selected;
- a set write leaves the written bits set;
- a mask-clear write leaves no bit set that the data held at 0;
- a level trigger is captured on the next clock;
- in edge mode, no cause bit appears without a rising trigger or a set write.

The directed scenarios cover the rest:
- reset values and the read-back of write-only locations;
- the control bit pattern;
- the independence of the two group windows;
- the trigger-over-clear collision;
- the severity outputs as the masks open;
- re-arming of an edge-mode source once its trigger falls and rises again.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int unsigned SRC_W    = 32;
  localparam int unsigned WIN_BYTES = 64;
  localparam int unsigned OFF_W    = 6;

  localparam logic [OFF_W-1:0] OFF_CAUSE = 6'h00;
  localparam logic [OFF_W-1:0] OFF_SET   = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MASK  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 6'h18;
  localparam logic [OFF_W-1:0] OFF_STAT  = 6'h20;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 6'h28;
  localparam logic [OFF_W-1:0] OFF_AMSK  = 6'h30;
  localparam logic [OFF_W-1:0] OFF_FMSK  = 6'h34;
  localparam logic [OFF_W-1:0] OFF_LMSK  = 6'h38;

  localparam logic [SRC_W-1:0] CTRL_KEEP = 32'h0FFF_0F2F;
  localparam int unsigned      CTRL_EDGE_BIT = 3;

  typedef enum logic [3:0] {
    RK_NONE, RK_CAUSE, RK_SET, RK_MASK, RK_MCLR,
    RK_STAT, RK_CTRL, RK_AMSK, RK_FMSK, RK_LMSK
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input logic [OFF_W-1:0] off);
    case (off)
      OFF_CAUSE: kind_of = RK_CAUSE;
      OFF_SET:   kind_of = RK_SET;
      OFF_MASK:  kind_of = RK_MASK;
      OFF_MCLR:  kind_of = RK_MCLR;
      OFF_STAT:  kind_of = RK_STAT;
      OFF_CTRL:  kind_of = RK_CTRL;
      OFF_AMSK:  kind_of = RK_AMSK;
      OFF_FMSK:  kind_of = RK_FMSK;
      OFF_LMSK:  kind_of = RK_LMSK;
      default:   kind_of = RK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_win_dec.sv
module irq_win_dec
  import irq_grp_pkg::*;
#(
  parameter int unsigned NGROUPS = 2,
  parameter int unsigned AW      = 7,
  localparam int unsigned GW     = (NGROUPS > 1) ? $clog2(NGROUPS) : 1
) (
  input  logic [AW-1:0]      addr_i,
  output logic [NGROUPS-1:0] sel_o,
  output logic [GW-1:0]      grp_o,
  output logic [OFF_W-1:0]   off_o
);
  logic [GW-1:0] grp_raw;

  generate
    if (AW > OFF_W) begin : g_multi
      assign grp_raw = GW'(addr_i[AW-1:OFF_W]);
    end else begin : g_single
      assign grp_raw = '0;
    end
  endgenerate

  assign grp_o = grp_raw;
  assign off_o = addr_i[OFF_W-1:0];

  always_comb begin
    sel_o = '0;
    for (int g = 0; g < NGROUPS; g++) begin
      if (grp_raw == GW'(g)) sel_o[g] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_grp_core.sv
module irq_grp_core
  import irq_grp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] trig_i,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] rdata_o,
  output logic             abort_o,
  output logic             fatal_o,
  output logic             log_o
);
  logic [SRC_W-1:0] cause_q, cause_d;
  logic [SRC_W-1:0] mask_q, mask_d;
  logic [SRC_W-1:0] ctrl_q, amsk_q, fmsk_q, lmsk_q;
  logic [SRC_W-1:0] trig_q, trig_hit;
  reg_kind_e        kind;
  logic wr_cause, wr_set, wr_mask, wr_mclr, wr_ctrl, wr_amsk, wr_fmsk, wr_lmsk;
  logic edge_mode;

  assign kind      = kind_of(off_i);
  assign edge_mode = ctrl_q[CTRL_EDGE_BIT];

  always_comb begin
    wr_cause = wr_i && (kind == RK_CAUSE);
    wr_set   = wr_i && (kind == RK_SET);
    wr_mask  = wr_i && (kind == RK_MASK);
    wr_mclr  = wr_i && (kind == RK_MCLR);
    wr_ctrl  = wr_i && (kind == RK_CTRL);
    wr_amsk  = wr_i && (kind == RK_AMSK);
    wr_fmsk  = wr_i && (kind == RK_FMSK);
    wr_lmsk  = wr_i && (kind == RK_LMSK);
  end

  // next state: trigger capture has priority over a software clear
  always_comb begin
    trig_hit = edge_mode ? (trig_i & ~trig_q) : trig_i;
    cause_d  = cause_q;
    if (wr_cause) cause_d = cause_d & wdata_i;
    if (wr_set)   cause_d = cause_d | wdata_i;
    cause_d = cause_d | trig_hit;
    if (wr_mask)      mask_d = wdata_i;
    else if (wr_mclr) mask_d = mask_q & wdata_i;
    else              mask_d = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      trig_q  <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_d;
      trig_q  <= trig_i;
      if (wr_mask || wr_mclr) mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      amsk_q <= '1;
      fmsk_q <= '1;
      lmsk_q <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i & CTRL_KEEP;
      if (wr_amsk) amsk_q <= wdata_i;
      if (wr_fmsk) fmsk_q <= wdata_i;
      if (wr_lmsk) lmsk_q <= wdata_i;
    end
  end

  always_comb begin
    case (kind)
      RK_CAUSE: rdata_o = cause_q;
      RK_MASK:  rdata_o = mask_q;
      RK_STAT:  rdata_o = cause_q & ~mask_q;
      RK_CTRL:  rdata_o = ctrl_q;
      RK_AMSK:  rdata_o = amsk_q;
      RK_FMSK:  rdata_o = fmsk_q;
      RK_LMSK:  rdata_o = lmsk_q;
      default:  rdata_o = '0;
    endcase
  end

  assign abort_o = |(cause_q & ~amsk_q);
  assign fatal_o = |(cause_q & ~fmsk_q);
  assign log_o   = |(cause_q & ~lmsk_q);

  assert_set_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((cause_q & $past(wdata_i)) == $past(wdata_i)));

  assert_mclr_only_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask_q & ~$past(wdata_i)) == '0));

  assert_level_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && (trig_i != '0)) |=> ((cause_q & $past(trig_i)) == $past(trig_i)));

  assert_edge_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !wr_set && ((trig_i & ~trig_q) == '0))
      |=> ((cause_q & ~$past(cause_q)) == '0));
endmodule

// File: rtl/irq_grp_bank.sv
module irq_grp_bank
  import irq_grp_pkg::*;
#(
  parameter int unsigned NGROUPS = 2,
  localparam int unsigned AW     = $clog2(WIN_BYTES * NGROUPS),
  localparam int unsigned GW     = (NGROUPS > 1) ? $clog2(NGROUPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NGROUPS*SRC_W-1:0] trig_i,
  input  logic [AW-1:0]            addr_i,
  input  logic                     wr_en_i,
  input  logic [SRC_W-1:0]         wdata_i,
  output logic [SRC_W-1:0]         rdata_o,
  output logic [NGROUPS-1:0]       grp_abort_o,
  output logic [NGROUPS-1:0]       grp_fatal_o,
  output logic [NGROUPS-1:0]       grp_log_o,
  output logic                     any_abort_o,
  output logic                     any_fatal_o,
  output logic                     any_log_o
);
  logic [NGROUPS-1:0] sel;
  logic [GW-1:0]      grp;
  logic [OFF_W-1:0]   off;
  logic [SRC_W-1:0]   grp_rdata [NGROUPS];

  irq_win_dec #(.NGROUPS(NGROUPS), .AW(AW)) i_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .grp_o  (grp),
    .off_o  (off)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    irq_grp_core i_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (trig_i[g*SRC_W +: SRC_W]),
      .wr_i    (wr_en_i && sel[g]),
      .off_i   (off),
      .wdata_i (wdata_i),
      .rdata_o (grp_rdata[g]),
      .abort_o (grp_abort_o[g]),
      .fatal_o (grp_fatal_o[g]),
      .log_o   (grp_log_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NGROUPS; g++) begin
      if (sel[g]) rdata_o = grp_rdata[g];
    end
  end

  assign any_abort_o = |grp_abort_o;
  assign any_fatal_o = |grp_fatal_o;
  assign any_log_o   = |grp_log_o;

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: tb/test_irq_grp_bank.sv
module test_irq_grp_bank;
  localparam int NG = 2;
  localparam int AW = 7;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NG*32-1:0] trig;
  logic [AW-1:0]   addr;
  logic            wr_en;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NG-1:0]   g_ab, g_fa, g_lo;
  logic            a_ab, a_fa, a_lo;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_grp_bank #(.NGROUPS(NG)) i_irq_grp_bank (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .grp_abort_o(g_ab), .grp_fatal_o(g_fa),
    .grp_log_o(g_lo), .any_abort_o(a_ab), .any_fatal_o(a_fa), .any_log_o(a_lo)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(int g, logic [5:0] off, logic [31:0] d);
    @(negedge clk);
    addr = AW'(g * 64 + off); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int g, logic [5:0] off, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(g * 64 + off);
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 6'h00, v); chk("R2 cause", v, 32'h0);
    rd(0, 6'h10, v); chk("R2 mask", v, 32'h0);
    rd(0, 6'h28, v); chk("R2 ctrl", v, 32'h0);
    rd(1, 6'h30, v); chk("R2 abort mask", v, 32'hFFFF_FFFF);
    rd(1, 6'h34, v); chk("R2 fatal mask", v, 32'hFFFF_FFFF);
    rd(0, 6'h38, v); chk("R2 log mask", v, 32'hFFFF_FFFF);
    chk("R2 outputs", {26'h0, g_ab, g_fa, g_lo}, 32'h0);
  endtask

  task automatic t_cause();
    logic [31:0] v;
    wr(0, 6'h08, 32'h0000_00F0);
    rd(0, 6'h00, v); chk("R4 set", v, 32'h0000_00F0);
    wr(0, 6'h00, ~32'h0000_0030);
    rd(0, 6'h00, v); chk("R3 w0c", v, 32'h0000_00C0);
    rd(0, 6'h08, v); chk("R8 set reads 0", v, 32'h0);
    rd(1, 6'h00, v); chk("R1 group1 untouched", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(0, 6'h10, 32'hFF00_FF00);
    rd(0, 6'h10, v); chk("R5 mask load", v, 32'hFF00_FF00);
    wr(0, 6'h18, 32'hF0FF_FFFF);
    rd(0, 6'h10, v); chk("R5 mask clear", v, 32'hF000_FF00);
    rd(0, 6'h18, v); chk("R8 mclr reads 0", v, 32'h0);
    rd(0, 6'h20, v); chk("R6 status", v, 32'h0000_00C0);
    wr(0, 6'h10, 32'h0000_0080);
    rd(0, 6'h20, v); chk("R6 status masked", v, 32'h0000_0040);
    wr(0, 6'h20, 32'h0);
    rd(0, 6'h00, v); chk("R6 status write ignored", v, 32'h0000_00C0);
    rd(1, 6'h10, v); chk("R1 group1 mask", v, 32'h0);
  endtask

  task automatic t_ctrl_unmapped();
    logic [31:0] v;
    wr(0, 6'h28, 32'hFFFF_FFFF);
    rd(0, 6'h28, v); chk("R7 ctrl readback", v, 32'h0FFF_0F2F);
    wr(0, 6'h28, 32'h0);
    wr(0, 6'h04, 32'hFFFF_FFFF);
    rd(0, 6'h04, v); chk("R1 unmapped 04", v, 32'h0);
    rd(0, 6'h2C, v); chk("R1 unmapped 2C", v, 32'h0);
    rd(0, 6'h00, v); chk("R1 unmapped write no effect", v, 32'h0000_00C0);
  endtask

  task automatic t_sev();
    logic [31:0] v;
    chk("R11 abort masked", {31'h0, g_ab[0]}, 32'h0);
    wr(0, 6'h30, 32'hFFFF_FFBF);
    #1;
    chk("R11 abort g0", {30'h0, g_ab}, 32'h1);
    chk("R12 any abort", {31'h0, a_ab}, 32'h1);
    chk("R11 fatal stays", {30'h0, g_fa}, 32'h0);
    wr(0, 6'h10, 32'hFFFF_FFFF);
    #1 chk("R11 status mask no effect", {31'h0, g_ab[0]}, 32'h1);
    wr(1, 6'h38, 32'hFFFF_FFFE);
    #1 chk("R11 log g1 idle", {30'h0, g_lo}, 32'h0);
    wr(1, 6'h08, 32'h1);
    #1 chk("R11 log g1", {30'h0, g_lo}, 32'h2);
    chk("R12 any log", {31'h0, a_lo}, 32'h1);
    wr(0, 6'h30, 32'hFFFF_FFFF);
    #1 chk("R12 any abort off", {31'h0, a_ab}, 32'h0);
    rd(1, 6'h00, v);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk); trig[3] = 1'b1;
    @(negedge clk);
    rd(0, 6'h00, v); chk("R9 level capture", v & 32'h8, 32'h8);
    wr(0, 6'h00, 32'h0);
    rd(0, 6'h00, v); chk("R9 trigger wins clear", v, 32'h8);
    @(negedge clk); trig[3] = 1'b0;
    wr(0, 6'h00, 32'h0);
    rd(0, 6'h00, v); chk("R9 cleared after drop", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(1, 6'h28, 32'h8);
    wr(1, 6'h00, 32'h0);
    @(negedge clk); trig[32+2] = 1'b1;
    @(negedge clk);
    rd(1, 6'h00, v); chk("R10 edge capture", v, 32'h4);
    wr(1, 6'h00, 32'h0);
    repeat (3) @(negedge clk);
    rd(1, 6'h00, v); chk("R10 held no reset", v, 32'h0);
    trig[32+2] = 1'b0;
    @(negedge clk); trig[32+2] = 1'b1;
    @(negedge clk);
    rd(1, 6'h00, v); chk("R10 re-arm", v, 32'h4);
    trig[32+2] = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trig = '0; addr = '0; wr_en = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cause();
    t_mask();
    t_ctrl_unmapped();
    t_sev();
    t_level();
    t_edge();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule